// File: doc/BRIEF.md
# Alarm Countdown Timer with Snooze

This block is a wake-up timer that runs from a slow, audio-rate clock. Reset arms it with a long delay, about eight hours at the default 1024 Hz clock, and it counts down one step per clock edge. When the count reaches zero the alarm becomes active. The running clock is then gated onto the tone pin, which gives an audible square wave without a separate oscillator.

A snooze push-button acts only while the alarm sounds. The button is synchronised and edge-detected. A press silences the tone, reloads a much shorter delay (about fifteen minutes by default) and restarts the countdown. Presses made while the countdown is still running are ignored. Reset always wins over snooze.

Top module: `alarm_timer`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after its release, `count_o` equals RESET_LOAD and `alarm_o` and `tone_o` are 0.
- R2: While the count is nonzero, each rising clock edge lowers `count_o` by exactly one.
- R3: The edge that takes the count from 1 to 0 raises `alarm_o`. After that the count holds at 0 and never wraps, and `alarm_o` stays 1 until a snooze reload or a reset.
- R4: `tone_o` follows the clock while the alarm is active. Its enable updates only during the clock's low phase, so `tone_o` first goes high on the rising edge after `alarm_o` rises and stays low from the first falling edge after `alarm_o` falls.
- R5: `snooze_i` passes through a two-flop synchroniser and a rising-edge detector. When `snooze_i` rises during an alarm, the third rising edge after the change loads SNOOZE_LOAD into `count_o` and clears `alarm_o`.
- R6: A snooze press while `alarm_o` is 0 has no effect. The countdown continues unchanged.
- R7: A press held for any length of time causes at most one reload. Holding the button through a later zero crossing does not reload again.
- R8: Reset overrides a pending snooze press. After reset the count is RESET_LOAD, and a button still held at reset release does not reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Audio-rate counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loads the long delay |
| snooze_i | input | 1 | Asynchronous snooze push-button, active high |
| tone_o | output | 1 | Clock gated by the alarm state |
| alarm_o | output | 1 | High while the alarm is sounding |
| count_o | output | CNT_W | Remaining countdown cycles |

## Verification
The bench builds the timer with RESET_LOAD = 40 and SNOOZE_LOAD = 12 rather than the multi-million-cycle defaults. With these values the full reset countdown, the zero hold, two snooze reloads and a second zero crossing all fit within a few hundred cycles. The short loads keep the counter at 6 bits, so a wrap below zero would show up as 63 at once. They also make exact cycle positions easy to predict: the three-edge snooze latency, the half-cycle delay of the tone enable, and a reset that lands while a press is still in the synchroniser.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic {
    ST_COUNT = 1'b0,
    ST_ALARM = 1'b1
  } alarm_state_e;

  localparam int unsigned DEF_RESET_LOAD  = 29_491_200;
  localparam int unsigned DEF_SNOOZE_LOAD = 921_600;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/alarm_btn_sync.sv
module alarm_btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= btn_i;
        else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_pkg::*;
#(
  parameter int unsigned CNT_W       = 25,
  parameter int unsigned RESET_LOAD  = DEF_RESET_LOAD,
  parameter int unsigned SNOOZE_LOAD = DEF_SNOOZE_LOAD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snz_pulse_i,
  output logic [CNT_W-1:0] count_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_LOAD);
  localparam logic [CNT_W-1:0] SNZ_VAL = CNT_W'(SNOOZE_LOAD);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  alarm_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_COUNT: begin
        // reaching zero arms the alarm; never decrement past zero
        if (cnt_q <= ONE) begin
          cnt_d   = '0;
          state_d = ST_ALARM;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_ALARM: begin
        if (snz_pulse_i) begin
          cnt_d   = SNZ_VAL;
          state_d = ST_COUNT;
        end
      end
      default: state_d = ST_COUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COUNT;
      cnt_q   <= RST_VAL;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign alarm_o = (state_q == ST_ALARM);
endmodule

// File: rtl/alarm_tone_gate.sv
module alarm_tone_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tone_o
);
  logic en_q;

  // capture on falling edge so the AND gate sees a stable enable while clk is high
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign tone_o = clk_i & en_q;
endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
  import alarm_pkg::*;
#(
  parameter int unsigned RESET_LOAD  = DEF_RESET_LOAD,
  parameter int unsigned SNOOZE_LOAD = DEF_SNOOZE_LOAD,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned CNT_W       = $clog2(RESET_LOAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snooze_i,
  output logic             tone_o,
  output logic             alarm_o,
  output logic [CNT_W-1:0] count_o
);
  logic snz_pulse;
  logic alarm;

  alarm_btn_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .btn_i (snooze_i),
    .rise_o(snz_pulse)
  );

  alarm_countdown #(
    .CNT_W      (CNT_W),
    .RESET_LOAD (RESET_LOAD),
    .SNOOZE_LOAD(SNOOZE_LOAD)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .snz_pulse_i(snz_pulse),
    .count_o    (count_o),
    .alarm_o    (alarm)
  );

  alarm_tone_gate u_tone (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (alarm),
    .tone_o(tone_o)
  );

  assign alarm_o = alarm;
endmodule

// File: rtl/alarm_timer_chk.sv
module alarm_timer_chk #(
  parameter int unsigned RESET_LOAD  = 40,
  parameter int unsigned SNOOZE_LOAD = 12,
  parameter int unsigned CNT_W       = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             snz_pulse_i,
  input logic             alarm_o,
  input logic [CNT_W-1:0] count_o
);
  AST_RESET_LOAD: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (count_o == CNT_W'(RESET_LOAD)) && !alarm_o); // R1

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1))); // R2

  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !snz_pulse_i) |=> (alarm_o && count_o == '0)); // R3

  AST_ALARM_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> (count_o == '0)); // R3

  AST_SNOOZE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && snz_pulse_i) |=> (!alarm_o && count_o == CNT_W'(SNOOZE_LOAD))); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snz_pulse_i |=> !snz_pulse_i); // R7
endmodule

bind alarm_timer alarm_timer_chk #(
  .RESET_LOAD (RESET_LOAD),
  .SNOOZE_LOAD(SNOOZE_LOAD),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .snz_pulse_i(snz_pulse),
  .alarm_o    (alarm_o),
  .count_o    (count_o)
);

// File: tb/alarm_timer_tb.sv
module alarm_timer_tb;
  localparam int unsigned RL = 40;
  localparam int unsigned SL = 12;
  localparam int unsigned CW = $clog2(RL + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          snooze_i = 1'b0;
  logic          tone_o;
  logic          alarm_o;
  logic [CW-1:0] count_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  alarm_timer #(
    .RESET_LOAD (RL),
    .SNOOZE_LOAD(SL),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .snooze_i(snooze_i),
    .tone_o  (tone_o),
    .alarm_o (alarm_o),
    .count_o (count_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    tick(3);
    chk("R1", "count in reset", int'(count_o), RL);
    chk("R1", "alarm in reset", int'(alarm_o), 0);
    chk("R1", "tone in reset",  int'(tone_o), 0);
    rst_ni = 1'b1;
    #0;
    chk("R1", "count after release", int'(count_o), RL);
  endtask

  task automatic t_countdown();
    tick(5);
    chk("R2", "count after 5 edges", int'(count_o), RL - 5);
    tick(1);
    chk("R2", "count after 6 edges", int'(count_o), RL - 6);
  endtask

  task automatic t_ignored();
    snooze_i = 1'b1;
    tick(4);
    chk("R6", "count with early press", int'(count_o), RL - 10);
    chk("R6", "alarm with early press", int'(alarm_o), 0);
    snooze_i = 1'b0;
    tick(1);
    chk("R6", "count after early release", int'(count_o), RL - 11);
  endtask

  task automatic t_alarm();
    tick(RL - 12);
    chk("R2", "count at one", int'(count_o), 1);
    chk("R3", "alarm before zero", int'(alarm_o), 0);
    tick(1);
    chk("R3", "count at zero", int'(count_o), 0);
    chk("R3", "alarm at zero", int'(alarm_o), 1);
    chk("R4", "tone before enable", int'(tone_o), 0);
    tick(1);
    chk("R4", "tone high phase", int'(tone_o), 1);
    @(negedge clk_i); #1;
    chk("R4", "tone low phase", int'(tone_o), 0);
    tick(10);
    chk("R3", "count holds zero", int'(count_o), 0);
    chk("R3", "alarm holds", int'(alarm_o), 1);
  endtask

  task automatic t_snooze_held();
    snooze_i = 1'b1;
    tick(2);
    chk("R5", "count before reload", int'(count_o), 0);
    chk("R5", "alarm before reload", int'(alarm_o), 1);
    tick(1);
    chk("R5", "snooze reload", int'(count_o), SL);
    chk("R5", "alarm cleared", int'(alarm_o), 0);
    chk("R4", "tone lingers to negedge", int'(tone_o), 1);
    tick(1);
    chk("R4", "tone off after snooze", int'(tone_o), 0);
    chk("R2", "count after reload", int'(count_o), SL - 1);
    tick(SL - 1);
    chk("R3", "second zero", int'(count_o), 0);
    chk("R3", "second alarm", int'(alarm_o), 1);
    tick(5);
    chk("R7", "held press no reload", int'(count_o), 0);
    chk("R7", "held press alarm stays", int'(alarm_o), 1);
    snooze_i = 1'b0;
    tick(2);
  endtask

  task automatic t_snooze_again();
    snooze_i = 1'b1;
    tick(3);
    chk("R5", "second press reload", int'(count_o), SL);
    snooze_i = 1'b0;
    tick(SL);
    chk("R3", "third alarm", int'(alarm_o), 1);
  endtask

  task automatic t_reset_prio();
    snooze_i = 1'b1;
    tick(2);
    rst_ni = 1'b0;
    tick(1);
    chk("R8", "reset over snooze count", int'(count_o), RL);
    chk("R8", "reset over snooze alarm", int'(alarm_o), 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R8", "held press after reset", int'(count_o), RL - 4);
    snooze_i = 1'b0;
    tick(1);
  endtask

  initial begin
    t_reset();
    t_countdown();
    t_ignored();
    t_alarm();
    t_snooze_held();
    t_snooze_again();
    t_reset_prio();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule